// File: doc/BRIEF.md
# Converter Built-In-Test Fault Monitor

This block watches the health of a tracking angle converter and folds every fault it finds into one active-low test output. It receives digitized magnitudes of the sine, cosine and reference channels, the signed tracking error from the demodulator in LSBs, and a polarity flag that goes high when the input signal sits 180 degrees away from the reference (a false null).

Four faults are recognised. Loss of signal means both the sine and cosine magnitudes are low. Loss of reference means the reference magnitude is low. Excessive error means the tracking error is too large. A false null is the fourth fault. The excessive-error fault is qualified: the condition must hold without a break for a programmable number of clock cycles before it counts. At reset the error fault starts out asserted, so the output stays low until the loop has settled. A false null also sends a one-clock kickstart request to the angle counter.

Top module: `bit_fault_monitor`

## Requirements
- R1: `bit_n` is a registered active-low output. It is 1 exactly when no fault flag was set on the previous clock. While `rst` is high, `bit_n` is 0 and `kick` is 0.
- R2: Loss of signal is set when `sin_mag < LOSS_THR` and `cos_mag < LOSS_THR` are both true, using unsigned compares. After the input changes, `bit_n` follows on the second rising edge. If only one of the two channels is low, no fault is raised.
- R3: Loss of reference is set when `ref_mag < LOSS_THR`, using an unsigned compare. After the input changes, `bit_n` follows on the second rising edge.
- R4: A tracking error is over the limit when its two's-complement magnitude exceeds `ERR_LIM`. Once the over-limit condition starts, it must hold for `DLY_CYC` consecutive rising edges before the error fault sets. `bit_n` falls on edge `DLY_CYC+1` and not before.
- R5: The first edge that sees the error within the limit clears the error fault and restarts the delay count. An interruption of one cycle therefore restarts the full delay.
- R6: When `phase_inv` is high, a false-null fault is raised. It reaches `bit_n` on the second rising edge.
- R7: `kick` is high for exactly one cycle, on the first edge after `phase_inv` rises. Holding `phase_inv` high produces no further pulses.
- R8: The error fault is asserted by reset. If the error is within the limit after reset, `bit_n` rises on the second edge. If the error stays over the limit, `bit_n` stays low indefinitely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sin_mag | input | MAG_W | Sine channel magnitude |
| cos_mag | input | MAG_W | Cosine channel magnitude |
| ref_mag | input | MAG_W | Reference magnitude |
| trk_err | input | ERR_W | Signed tracking error in LSBs |
| phase_inv | input | 1 | High when the signal is inverted relative to the reference |
| bit_n | output | 1 | Active-low combined fault output |
| kick | output | 1 | One-cycle kickstart request to the angle counter |

## Verification
The most delicate state in this block is the qualification counter. If it ran one count too long or too short, the falling edge of `bit_n` would move by one cycle from edge `DLY_CYC+1`. If it failed to clear when the error dropped out, a broken run of over-limit errors would still trip the fault too early. A stuck edge-detect register would show up as either a repeating `kick` or a missing `kick` within two cycles of `phase_inv` rising. A wrong threshold comparison, or a flag that stuck set, would show on `bit_n` within two edges of the input that triggers it.

// File: rtl/bit_pkg.sv
package bit_pkg;
  typedef struct packed {
    logic sig_loss;
    logic ref_loss;
    logic err_over;
    logic inv_null;
  } fault_vec_t;
endpackage

// File: rtl/bit_level_cmp.sv
module bit_level_cmp #(
  parameter int MAG_W  = 12,
  parameter int N_CH   = 2,
  parameter int THRESH = 410
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [N_CH*MAG_W-1:0] mags,
  output logic                  low_all
);
  localparam logic [MAG_W-1:0] THR_V = THRESH[MAG_W-1:0];

  logic [N_CH-1:0] below;

  generate
    for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
      assign below[ch] = mags[ch*MAG_W +: MAG_W] < THR_V;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) low_all <= 1'b0;
    else     low_all <= &below;
  end
endmodule

// File: rtl/bit_err_qual.sv
module bit_err_qual #(
  parameter int ERR_W   = 16,
  parameter int ERR_LIM = 100,
  parameter int DLY_CYC = 125000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ERR_W-1:0] err,
  output logic             fault
);
  localparam int CW = $clog2(DLY_CYC + 1);
  localparam logic [CW-1:0]  LAST  = CW'(DLY_CYC - 1);
  localparam logic [ERR_W:0] LIM_V = ERR_LIM[ERR_W:0];

  logic signed [ERR_W:0] ext;
  logic [ERR_W:0]        mag;
  logic                  over;
  logic [CW-1:0]         cnt;

  always_comb begin
    ext  = {err[ERR_W-1], err};
    mag  = ext[ERR_W] ? ERR_W'(0) - ext : ext;
    over = mag > LIM_V;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      fault <= 1'b1;
    end else if (!over) begin
      cnt   <= '0;
      fault <= 1'b0;
    end else if (!fault) begin
      if (cnt == LAST) fault <= 1'b1;
      else             cnt   <= cnt + 1'b1;
    end
  end

  AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST); // R4
  AST_ERR_CLEARS_FAST: assert property (@(posedge clk) disable iff (rst)
    !over |=> !fault); // R5
  AST_ERR_QUAL_AT_LAST: assert property (@(posedge clk) disable iff (rst)
    (over && !fault && cnt != LAST) |=> !fault); // R4
endmodule

// File: rtl/bit_null_kick.sv
module bit_null_kick (
  input  logic clk,
  input  logic rst,
  input  logic inv_in,
  output logic null_flag,
  output logic kick
);
  always_ff @(posedge clk) begin
    if (rst) begin
      null_flag <= 1'b0;
      kick      <= 1'b0;
    end else begin
      null_flag <= inv_in;
      kick      <= inv_in & ~null_flag;
    end
  end

  AST_KICK_SINGLE: assert property (@(posedge clk) disable iff (rst)
    kick |=> !kick); // R7
  AST_KICK_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    (null_flag && !kick) |=> !kick); // R7
endmodule

// File: rtl/bit_fault_monitor.sv
module bit_fault_monitor #(
  parameter int MAG_W    = 12,
  parameter int LOSS_THR = 410,
  parameter int ERR_W    = 16,
  parameter int ERR_LIM  = 100,
  parameter int DLY_CYC  = 125000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [MAG_W-1:0] sin_mag,
  input  logic [MAG_W-1:0] cos_mag,
  input  logic [MAG_W-1:0] ref_mag,
  input  logic [ERR_W-1:0] trk_err,
  input  logic             phase_inv,
  output logic             bit_n,
  output logic             kick
);
  import bit_pkg::*;

  fault_vec_t flags;

  bit_level_cmp #(.MAG_W(MAG_W), .N_CH(2), .THRESH(LOSS_THR)) i_sig (
    .clk(clk), .rst(rst), .mags({cos_mag, sin_mag}), .low_all(flags.sig_loss));

  bit_level_cmp #(.MAG_W(MAG_W), .N_CH(1), .THRESH(LOSS_THR)) i_ref (
    .clk(clk), .rst(rst), .mags(ref_mag), .low_all(flags.ref_loss));

  bit_err_qual #(.ERR_W(ERR_W), .ERR_LIM(ERR_LIM), .DLY_CYC(DLY_CYC)) i_err (
    .clk(clk), .rst(rst), .err(trk_err), .fault(flags.err_over));

  bit_null_kick i_null (
    .clk(clk), .rst(rst), .inv_in(phase_inv),
    .null_flag(flags.inv_null), .kick(kick));

  always_ff @(posedge clk) begin
    if (rst) bit_n <= 1'b0;
    else     bit_n <= ~(|flags);
  end

  AST_FAULT_DRIVES_LOW: assert property (@(posedge clk) disable iff (rst)
    (|flags) |=> !bit_n); // R1
  AST_CLEAN_DRIVES_HIGH: assert property (@(posedge clk) disable iff (rst)
    !(|flags) |=> bit_n); // R1
  AST_KICK_RAISES_NULL: assert property (@(posedge clk) disable iff (rst)
    kick |-> flags.inv_null); // R6
endmodule

// File: tb/test_bit_fault_monitor.sv
module test_bit_fault_monitor;
  localparam int MW  = 6;
  localparam int THR = 20;
  localparam int EW  = 8;
  localparam int LIM = 10;
  localparam int DLY = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [MW-1:0] sin_mag = '1, cos_mag = '1, ref_mag = '1;
  logic [EW-1:0] trk_err = '0;
  logic phase_inv = 1'b0;
  logic bit_n, kick;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  bit_fault_monitor #(.MAG_W(MW), .LOSS_THR(THR), .ERR_W(EW),
                      .ERR_LIM(LIM), .DLY_CYC(DLY)) i_bit_fault_monitor (
    .clk(clk), .rst(rst), .sin_mag(sin_mag), .cos_mag(cos_mag),
    .ref_mag(ref_mag), .trk_err(trk_err), .phase_inv(phase_inv),
    .bit_n(bit_n), .kick(kick));

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [EW-1:0] e);
    rst = 1'b1; trk_err = e; phase_inv = 1'b0;
    sin_mag = '1; cos_mag = '1; ref_mag = '1;
    step(2);
    chk("R1 reset bit_n", bit_n, 1'b0);
    chk("R1 reset kick", kick, 1'b0);
    rst = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R8: error within limit after reset
    do_reset('0);
    step(1);
    chk("R8 held low first edge", bit_n, 1'b0);
    step(1);
    chk("R8 rises when settled", bit_n, 1'b1);

    // R8: large error from reset keeps output low
    do_reset(EW'(50));
    for (int i = 0; i < DLY + 5; i++) begin
      step(1);
      chk("R8 stays low", bit_n, 1'b0);
    end
    trk_err = '0;
    step(2);
    chk("R8 release", bit_n, 1'b1);

    // R2: exhaustive sine/cosine sweep
    for (int s = 0; s < (1 << MW); s++)
      for (int c = 0; c < (1 << MW); c++) begin
        sin_mag = MW'(s); cos_mag = MW'(c);
        step(2);
        chk("R2 signal loss", bit_n, !((s < THR) && (c < THR)));
      end
    sin_mag = '1; cos_mag = '1;

    // R3: reference sweep
    for (int r = 0; r < (1 << MW); r++) begin
      ref_mag = MW'(r);
      step(2);
      chk("R3 reference loss", bit_n, !(r < THR));
    end
    ref_mag = '1;
    step(2);

    // R4: every error value, qualification edge exact
    for (int e = -(1 << (EW - 1)); e < (1 << (EW - 1)); e++) begin
      int m;
      m = (e < 0) ? -e : e;
      trk_err = EW'(e);
      step(DLY);
      chk("R4 not before delay", bit_n, 1'b1);
      step(1);
      chk("R4 after delay", bit_n, !(m > LIM));
      trk_err = '0;
      step(2);
      chk("R5 clears", bit_n, 1'b1);
    end

    // R5: a one-cycle break restarts the count
    trk_err = EW'(LIM + 1);
    step(DLY - 1);
    trk_err = '0;
    step(1);
    trk_err = EW'(-(LIM + 1));
    step(DLY);
    chk("R5 restart still high", bit_n, 1'b1);
    step(1);
    chk("R5 restart low", bit_n, 1'b0);
    trk_err = '0;
    step(1);
    step(1);
    chk("R5 clears in two edges", bit_n, 1'b1);

    // R6/R7: false null and kick
    for (int rep = 0; rep < 2; rep++) begin
      phase_inv = 1'b1;
      step(1);
      chk("R7 kick pulse", kick, 1'b1);
      step(1);
      chk("R7 kick single", kick, 1'b0);
      chk("R6 null fault", bit_n, 1'b0);
      for (int i = 0; i < 5; i++) begin
        step(1);
        chk("R7 no repeat", kick, 1'b0);
        chk("R6 held", bit_n, 1'b0);
      end
      phase_inv = 1'b0;
      step(2);
      chk("R6 released", bit_n, 1'b1);
      chk("R7 idle", kick, 1'b0);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule